// File: doc/BRIEF.md
# Stack and Pointer Memory Sequencer

This block sequences every data-memory access of a small 8-bit core that goes through the stack pointer, through the 16-bit Y pointer, or into the low I/O window. The decoder hands over one request at a time: an operation code, the register data, a byte count for return addresses, the current Y value, an I/O index and a bit index. The block then drives a single-port synchronous SRAM, one byte per cycle, until the operation is complete.

The stack pointer lives inside the block and is published on `sp_out`. A push writes at the current SP and moves it down. A pop moves SP up and then reads. Y is taken from the request, which supplies the register pair with r29 as the high byte and r28 as the low byte. Y is returned on `y_out`, and a `y_wr` strobe marks the forms that change it. Bit set and bit clear are read-modify-write sequences on one byte of the 32-entry I/O window.

Top module: `stkmem_unit`

## Requirements
- R1: After reset, `busy`, `done`, `y_wr` and `mem_en` are 0, and `sp_out` is all ones (the top of the stack area).
- R2: A push (op 1) writes its bytes at STACK_BASE+SP, decrementing SP after each byte. A multi-byte push writes the most significant byte first, so the least significant byte ends at the lowest address. SP falls by the byte count.
- R3: A pop (op 2) increments SP and then reads at STACK_BASE+SP, repeating once per byte. The byte at the lowest address is the least significant. The result is right-aligned in `rd_data` with zero upper bytes.
- R4: SP is SP_W bits wide and wraps: a pop from all ones yields 0, and a push at 0 yields all ones.
- R5: `req_len` gives the byte count for push and pop. A value of 0 is treated as 1, and values above MAXB are limited to MAXB.
- R6: A plain Y store (op 3) writes the low data byte at the address formed by the low AW bits of Y. It returns Y unchanged on `y_out` with `y_wr` low.
- R7: A post-increment Y store (op 4) writes at Y and returns Y+1 modulo 2^16 on `y_out`, with `y_wr` high alongside `done`.
- R8: A pre-decrement Y store (op 5) forms Y-1 modulo 2^16 and writes at that new address. It returns the new Y with `y_wr` high alongside `done`.
- R9: A Y load (op 6) reads the byte at Y into `rd_data[7:0]` and returns Y unchanged.
- R10: Bit set (op 7) and bit clear (op 8) read IO_BASE+`req_io`, then write the same byte back with bit `req_bit` forced to 1 or 0 respectively. All other bits are preserved.
- R11: `busy` stays high for byte count + 1 cycles on a push or pop, and for 2 cycles on every other operation. `done` is high for exactly one cycle, in the first cycle after `busy` falls, and the results are valid in that cycle.
- R12: A request presented while `busy` is high has no effect.
- R13: Op codes 0 and 9 to 15 are not operations: they raise no `busy`, perform no memory access and leave SP unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken only when not busy |
| req_op | input | 4 | Operation code (see R2 to R13) |
| req_len | input | 2 | Byte count for push and pop |
| req_data | input | 24 | Register data or return address |
| req_y | input | 16 | Current Y pointer (r29 high, r28 low) |
| req_io | input | 5 | I/O window index for bit operations |
| req_bit | input | 3 | Bit index for bit operations |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 24 | Data from the last pop or load |
| sp_out | output | 9 | Stack pointer |
| y_out | output | 16 | Y value after the last Y operation |
| y_wr | output | 1 | Y must be written back to r29:r28 |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 12 | SRAM byte address |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data, one cycle after the access |

## Verification
The hardest cases to reach from the ports are the SP wrap at both ends and a second request arriving inside a running sequence. Both depend on history, not on the current request. The vector table first drains the stack exactly back to the reset value, then pops once more to cross zero, and then pushes to cross back. Every row carries the SP expected after the whole history up to that point. For the busy case, the bench holds a second push on the request port during the cycle after acceptance. It then proves the push was dropped, because SP moved by one byte only and the following pop returns the first value, not the intruder.

// File: rtl/stkmem_pkg.sv
`timescale 1ns/1ps
package stkmem_pkg;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_PUSH = 4'd1,
        OP_POP  = 4'd2,
        OP_STY  = 4'd3,
        OP_STYI = 4'd4,
        OP_STYD = 4'd5,
        OP_LDY  = 4'd6,
        OP_BSET = 4'd7,
        OP_BCLR = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_RMW  = 2'd2,
        ST_FIN  = 2'd3
    } st_e;

    localparam logic [3:0] OP_LAST = 4'd8;

endpackage

// File: rtl/stkmem_step.sv
`timescale 1ns/1ps
// Wrapping +1 / -1 stepper for a pointer of width W.
module stkmem_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         down_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (down_i) val_o = val_i - ONE;
        else        val_o = val_i + ONE;
    end
endmodule

// File: rtl/stkmem_align.sv
`timescale 1ns/1ps
// Right-aligns a popped value that was shifted in from the top byte.
module stkmem_align #(
    parameter  int MAXB = 3,
    parameter  int LW   = 2,
    localparam int DW   = 8 * MAXB
) (
    input  logic [DW-1:0] acc_i,
    input  logic [LW-1:0] len_i,
    output logic [DW-1:0] val_o
);
    logic [DW-1:0] cand [MAXB];

    for (genvar k = 0; k < MAXB; k++) begin : g_len
        assign cand[k] = acc_i >> (8 * (MAXB - 1 - k));
    end

    always_comb begin
        val_o = cand[0];
        for (int k = 1; k < MAXB; k++) begin
            if (int'(len_i) == k + 1) val_o = cand[k];
        end
    end
endmodule

// File: rtl/stkmem_bitop.sv
`timescale 1ns/1ps
// Forces one selected bit of a byte to the set/clear value.
module stkmem_bitop (
    input  logic [7:0] byte_i,
    input  logic [2:0] sel_i,
    input  logic       set_i,
    output logic [7:0] byte_o
);
    for (genvar b = 0; b < 8; b++) begin : g_bit
        assign byte_o[b] = (sel_i == 3'(b)) ? set_i : byte_i[b];
    end
endmodule

// File: rtl/stkmem_unit.sv
`timescale 1ns/1ps
module stkmem_unit
    import stkmem_pkg::*;
#(
    parameter  int AW   = 12,
    parameter  int SP_W = 9,
    parameter  int MAXB = 3,
    parameter  int YW   = 16,
    parameter  logic [AW-1:0] STACK_BASE = AW'(16'h0100),
    parameter  logic [AW-1:0] IO_BASE    = AW'(16'h0020),
    localparam int DW   = 8 * MAXB,
    localparam int LW   = $clog2(MAXB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [3:0]      req_op,
    input  logic [LW-1:0]   req_len,
    input  logic [DW-1:0]   req_data,
    input  logic [YW-1:0]   req_y,
    input  logic [4:0]      req_io,
    input  logic [2:0]      req_bit,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rd_data,
    output logic [SP_W-1:0] sp_out,
    output logic [YW-1:0]   y_out,
    output logic            y_wr,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata
);
    typedef struct packed {
        st_e             st;
        op_e             op;
        logic [LW-1:0]   len;
        logic [LW-1:0]   cnt;
        logic [DW-1:0]   data;
        logic [SP_W-1:0] sp;
        logic [YW-1:0]   y;
        logic [DW-1:0]   acc;
        logic            pend;
        logic [4:0]      io;
        logic [2:0]      bsel;
        logic [DW-1:0]   rd;
        logic [YW-1:0]   yout;
        logic            ywr;
        logic            done;
    } ctx_t;

    ctx_t r_q, r_d;

    logic [SP_W-1:0] sp_inc, sp_dec;
    logic [YW-1:0]   y_pre, y_post;
    logic [DW-1:0]   acc_cap, pop_val;
    logic [7:0]      rmw_byte;
    logic [LW-1:0]   len_fix;
    logic            req_ok, req_stack;
    logic [AW-1:0]   stk_cur, stk_nxt, io_addr, y_addr;

    // pointer steppers
    stkmem_step #(.W(SP_W)) u_sp_inc (.val_i(r_q.sp), .down_i(1'b0), .val_o(sp_inc));
    stkmem_step #(.W(SP_W)) u_sp_dec (.val_i(r_q.sp), .down_i(1'b1), .val_o(sp_dec));
    stkmem_step #(.W(YW))   u_y_pre  (.val_i(req_y),  .down_i(1'b1), .val_o(y_pre));
    stkmem_step #(.W(YW))   u_y_post (.val_i(r_q.y),  .down_i(1'b0), .val_o(y_post));

    // read data arriving for the access issued last cycle
    assign acc_cap = r_q.pend ? {mem_rdata, r_q.acc[DW-1:8]} : r_q.acc;

    stkmem_align #(.MAXB(MAXB), .LW(LW)) u_align (
        .acc_i (acc_cap),
        .len_i (r_q.len),
        .val_o (pop_val)
    );

    stkmem_bitop u_bitop (
        .byte_i (mem_rdata),
        .sel_i  (r_q.bsel),
        .set_i  (r_q.op == OP_BSET),
        .byte_o (rmw_byte)
    );

    assign req_ok    = (req_op != 4'd0) && (req_op <= OP_LAST);
    assign req_stack = (req_op == OP_PUSH) || (req_op == OP_POP);

    always_comb begin
        if (req_len == '0)               len_fix = LW'(1);
        else if (int'(req_len) > MAXB)   len_fix = LW'(MAXB);
        else                             len_fix = req_len;
    end

    assign stk_cur = STACK_BASE + AW'(r_q.sp);
    assign stk_nxt = STACK_BASE + AW'(sp_inc);
    assign io_addr = IO_BASE + AW'(r_q.io);
    assign y_addr  = r_q.y[AW-1:0];

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.ywr   = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && req_ok) begin
                    r_d.st   = ST_BEAT;
                    r_d.op   = op_e'(req_op);
                    r_d.len  = req_stack ? len_fix : LW'(1);
                    r_d.cnt  = req_stack ? len_fix - LW'(1) : '0;
                    r_d.data = req_data;
                    r_d.acc  = '0;
                    r_d.pend = 1'b0;
                    r_d.io   = req_io;
                    r_d.bsel = req_bit;
                    r_d.y    = (req_op == OP_STYD) ? y_pre : req_y;
                end
            end

            ST_BEAT: begin
                mem_en   = 1'b1;
                r_d.acc  = acc_cap;
                r_d.pend = 1'b0;
                unique case (r_q.op)
                    OP_PUSH: begin
                        mem_we    = 1'b1;
                        mem_addr  = stk_cur;
                        mem_wdata = r_q.data[8*int'(r_q.cnt) +: 8];
                        r_d.sp    = sp_dec;
                    end
                    OP_POP: begin
                        mem_addr = stk_nxt;
                        r_d.sp   = sp_inc;
                        r_d.pend = 1'b1;
                    end
                    OP_STY, OP_STYI, OP_STYD: begin
                        mem_we    = 1'b1;
                        mem_addr  = y_addr;
                        mem_wdata = r_q.data[7:0];
                    end
                    OP_LDY: begin
                        mem_addr = y_addr;
                        r_d.pend = 1'b1;
                    end
                    OP_BSET, OP_BCLR: begin
                        mem_addr = io_addr;
                        r_d.pend = 1'b1;
                    end
                    default: begin
                        mem_en = 1'b0;
                    end
                endcase
                if (r_q.op == OP_BSET || r_q.op == OP_BCLR) begin
                    r_d.st = ST_RMW;
                end else if (r_q.cnt == '0) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.cnt = r_q.cnt - LW'(1);
                end
            end

            ST_RMW: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = io_addr;
                mem_wdata = rmw_byte;
                r_d.pend  = 1'b0;
                r_d.done  = 1'b1;
                r_d.st    = ST_IDLE;
            end

            ST_FIN: begin
                r_d.acc  = acc_cap;
                r_d.pend = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
                unique case (r_q.op)
                    OP_POP:  r_d.rd = pop_val;
                    OP_LDY: begin
                        r_d.rd   = DW'(mem_rdata);
                        r_d.yout = r_q.y;
                    end
                    OP_STY:  r_d.yout = r_q.y;
                    OP_STYI: begin
                        r_d.yout = y_post;
                        r_d.ywr  = 1'b1;
                    end
                    OP_STYD: begin
                        r_d.yout = r_q.y;
                        r_d.ywr  = 1'b1;
                    end
                    default: ;
                endcase
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.op <= OP_NONE;
            r_q.sp <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign rd_data = r_q.rd;
    assign sp_out  = r_q.sp;
    assign y_out   = r_q.yout;
    assign y_wr    = r_q.ywr;

endmodule

// File: rtl/stkmem_chk.sv
`timescale 1ns/1ps
module stkmem_chk #(
    parameter int SP_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            y_wr,
    input logic            mem_en,
    input logic            mem_we,
    input logic [SP_W-1:0] sp_out
);
    // R11: completion strobe lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: completion is reported only once the sequence has ended
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: Y write-back strobe rides with completion
    p_ywr_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        y_wr |-> done);

    // R13: no memory traffic outside a sequence
    p_mem_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R2: a write is always an enabled access
    p_we_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R4: SP moves by exactly one, wrapping, per cycle
    p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp_out) |->
            (sp_out == SP_W'($past(sp_out) + 1'b1)) ||
            (sp_out == SP_W'($past(sp_out) - 1'b1)));

    // R12: SP changes only inside an accepted sequence
    p_sp_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp_out) |-> $past(busy));
endmodule

bind stkmem_unit stkmem_chk #(.SP_W(SP_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .y_wr   (y_wr),
    .mem_en (mem_en),
    .mem_we (mem_we),
    .sp_out (sp_out)
);

// File: tb/sim_stkmem_unit.sv
`timescale 1ns/1ps
module sim_stkmem_unit;
    import stkmem_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [1:0]  req_len = '0;
    logic [23:0] req_data = '0;
    logic [15:0] req_y = '0;
    logic [4:0]  req_io = '0;
    logic [2:0]  req_bit = '0;
    logic        busy, done, y_wr, mem_en, mem_we;
    logic [23:0] rd_data;
    logic [8:0]  sp_out;
    logic [15:0] y_out;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    always #2.5 clk = ~clk;

    stkmem_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_len(req_len), .req_data(req_data), .req_y(req_y), .req_io(req_io),
        .req_bit(req_bit), .busy(busy), .done(done), .rd_data(rd_data),
        .sp_out(sp_out), .y_out(y_out), .y_wr(y_wr), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // synchronous SRAM model, preset to addr ^ 0x5A during reset
    logic [7:0] mem [4096];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd1:       return "R2";
            4'd2:       return "R3";
            4'd3:       return "R6";
            4'd4:       return "R7";
            4'd5:       return "R8";
            4'd6:       return "R9";
            default:    return "R10";
        endcase
    endfunction

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  len;
        logic [23:0] data;
        logic [15:0] y;
        logic [4:0]  io;
        logic [2:0]  bt;
        logic        crd;
        logic        cy;
        logic [23:0] erd;
        logic [8:0]  esp;
        logic [15:0] ey;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{4'd1, 2'd1, 24'h0000A5, 16'h0000, 5'd0, 3'd0, 1'b0, 1'b0, 24'h0, 9'h1FE, 16'h0},      // R2 push 1
        '{4'd1, 2'd2, 24'h001234, 16'h0000, 5'd0, 3'd0, 1'b0, 1'b0, 24'h0, 9'h1FC, 16'h0},      // R2 push 2
        '{4'd2, 2'd2, 24'h0,      16'h0000, 5'd0, 3'd0, 1'b1, 1'b0, 24'h001234, 9'h1FE, 16'h0}, // R3 pop 2
        '{4'd2, 2'd1, 24'h0,      16'h0000, 5'd0, 3'd0, 1'b1, 1'b0, 24'h0000A5, 9'h1FF, 16'h0}, // R3 pop 1
        '{4'd1, 2'd3, 24'hABCDEF, 16'h0000, 5'd0, 3'd0, 1'b0, 1'b0, 24'h0, 9'h1FC, 16'h0},      // R2 push 3
        '{4'd2, 2'd3, 24'h0,      16'h0000, 5'd0, 3'd0, 1'b1, 1'b0, 24'hABCDEF, 9'h1FF, 16'h0}, // R3 pop 3
        '{4'd2, 2'd1, 24'h0,      16'h0000, 5'd0, 3'd0, 1'b1, 1'b0, 24'h00005A, 9'h000, 16'h0}, // R4 wrap up
        '{4'd1, 2'd1, 24'h000077, 16'h0000, 5'd0, 3'd0, 1'b0, 1'b0, 24'h0, 9'h1FF, 16'h0},      // R4 wrap down
        '{4'd2, 2'd1, 24'h0,      16'h0000, 5'd0, 3'd0, 1'b1, 1'b0, 24'h000077, 9'h000, 16'h0}, // R4
        '{4'd1, 2'd0, 24'h00003C, 16'h0000, 5'd0, 3'd0, 1'b0, 1'b0, 24'h0, 9'h1FF, 16'h0},      // R5 len 0
        '{4'd2, 2'd0, 24'h0,      16'h0000, 5'd0, 3'd0, 1'b1, 1'b0, 24'h00003C, 9'h000, 16'h0}, // R5 len 0
        '{4'd3, 2'd1, 24'h000011, 16'h0400, 5'd0, 3'd0, 1'b0, 1'b1, 24'h0, 9'h000, 16'h0400},   // R6
        '{4'd6, 2'd1, 24'h0,      16'h0400, 5'd0, 3'd0, 1'b1, 1'b1, 24'h000011, 9'h000, 16'h0400}, // R9
        '{4'd4, 2'd1, 24'h000022, 16'h0400, 5'd0, 3'd0, 1'b0, 1'b1, 24'h0, 9'h000, 16'h0401},   // R7
        '{4'd5, 2'd1, 24'h000033, 16'h0402, 5'd0, 3'd0, 1'b0, 1'b1, 24'h0, 9'h000, 16'h0401},   // R8
        '{4'd6, 2'd1, 24'h0,      16'h0401, 5'd0, 3'd0, 1'b1, 1'b1, 24'h000033, 9'h000, 16'h0401}, // R8 check
        '{4'd6, 2'd1, 24'h0,      16'h0400, 5'd0, 3'd0, 1'b1, 1'b1, 24'h000022, 9'h000, 16'h0400}, // R7 check
        '{4'd5, 2'd1, 24'h000044, 16'h0000, 5'd0, 3'd0, 1'b0, 1'b1, 24'h0, 9'h000, 16'hFFFF},   // R8 wrap
        '{4'd6, 2'd1, 24'h0,      16'hFFFF, 5'd0, 3'd0, 1'b1, 1'b1, 24'h000044, 9'h000, 16'hFFFF}, // R9
        '{4'd4, 2'd1, 24'h000055, 16'hFFFF, 5'd0, 3'd0, 1'b0, 1'b1, 24'h0, 9'h000, 16'h0000},   // R7 wrap
        '{4'd6, 2'd1, 24'h0,      16'h0FFF, 5'd0, 3'd0, 1'b1, 1'b1, 24'h000055, 9'h000, 16'h0FFF}, // R9
        '{4'd7, 2'd1, 24'h0,      16'h0000, 5'd3, 3'd2, 1'b0, 1'b0, 24'h0, 9'h000, 16'h0},      // R10 set
        '{4'd6, 2'd1, 24'h0,      16'h0023, 5'd0, 3'd0, 1'b1, 1'b1, 24'h00007D, 9'h000, 16'h0023}, // R10 check
        '{4'd8, 2'd1, 24'h0,      16'h0000, 5'd3, 3'd0, 1'b0, 1'b0, 24'h0, 9'h000, 16'h0},      // R10 clear
        '{4'd6, 2'd1, 24'h0,      16'h0023, 5'd0, 3'd0, 1'b1, 1'b1, 24'h00007C, 9'h000, 16'h0023}, // R10 check
        '{4'd7, 2'd1, 24'h0,      16'h0000, 5'd31, 3'd7, 1'b0, 1'b0, 24'h0, 9'h000, 16'h0},     // R10 top bit
        '{4'd6, 2'd1, 24'h0,      16'h003F, 5'd0, 3'd0, 1'b1, 1'b1, 24'h0000E5, 9'h000, 16'h003F}  // R10 check
    };

    task automatic run_req(input logic [3:0] op, input logic [1:0] len,
                           input logic [23:0] data, input logic [15:0] y,
                           input logic [4:0] io, input logic [2:0] bt,
                           output int bc);
        @(negedge clk);
        req_op = op; req_len = len; req_data = data; req_y = y;
        req_io = io; req_bit = bt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_op = '0;
        bc = 0;
        while (busy && bc < 40) begin
            bc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int bc;
        int exp_bc;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 state while and right after reset
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy",   32'(busy),   32'd0);
        chk("R1", "done",   32'(done),   32'd0);
        chk("R1", "y_wr",   32'(y_wr),   32'd0);
        chk("R1", "mem_en", 32'(mem_en), 32'd0);
        chk("R1", "sp",     32'(sp_out), 32'h1FF);

        // R13 codes outside the operation set are dropped
        req_op = 4'd0; req_valid = 1'b1;
        @(negedge clk);
        chk("R13", "busy op0", 32'(busy), 32'd0);
        req_op = 4'd9;
        @(negedge clk);
        chk("R13", "busy op9", 32'(busy), 32'd0);
        chk("R13", "mem_en op9", 32'(mem_en), 32'd0);
        req_op = 4'd15;
        @(negedge clk);
        req_valid = 1'b0; req_op = '0;
        chk("R13", "busy op15", 32'(busy), 32'd0);
        chk("R13", "sp", 32'(sp_out), 32'h1FF);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            run_req(v.op, v.len, v.data, v.y, v.io, v.bt, bc);
            if (v.op == 4'd1 || v.op == 4'd2)
                exp_bc = (v.len == 2'd0) ? 2 : int'(v.len) + 1;
            else
                exp_bc = 2;
            chk("R11", $sformatf("busy cycles row %0d", i), 32'(bc), 32'(exp_bc));
            chk("R11", $sformatf("done row %0d", i), 32'(done), 32'd1);
            chk(tag_of(v.op), $sformatf("sp row %0d", i), 32'(sp_out), 32'(v.esp));
            if (v.crd)
                chk(tag_of(v.op), $sformatf("rd row %0d", i), 32'(rd_data), 32'(v.erd));
            if (v.cy)
                chk(tag_of(v.op), $sformatf("y row %0d", i), 32'(y_out), 32'(v.ey));
            chk(tag_of(v.op), $sformatf("y_wr row %0d", i), 32'(y_wr),
                32'((v.op == 4'd4) || (v.op == 4'd5)));
        end

        // R11 done falls after one cycle
        @(negedge clk);
        chk("R11", "done pulse width", 32'(done), 32'd0);

        // R12 a push offered mid-sequence is dropped
        @(negedge clk);
        req_op = 4'd1; req_len = 2'd1; req_data = 24'h99; req_valid = 1'b1;
        @(negedge clk);
        chk("R12", "busy after accept", 32'(busy), 32'd1);
        req_data = 24'hEE;
        @(negedge clk);
        req_valid = 1'b0; req_op = '0;
        while (busy) @(negedge clk);
        chk("R12", "sp after single push", 32'(sp_out), 32'h1FF);
        @(negedge clk);
        chk("R12", "idle after push", 32'(busy), 32'd0);
        run_req(4'd2, 2'd1, 24'h0, 16'h0, 5'd0, 3'd0, bc);
        chk("R12", "pop returns first push", 32'(rd_data), 32'h99);
        chk("R12", "sp after pop", 32'(sp_out), 32'h000);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule